// File: doc/BRIEF.md
# SEC-DED Protected Quadword Memory Controller

This block sits between a host request port and a 72-bit-wide synchronous memory array. Each word holds a 64-bit quadword and an 8-bit check byte. On every full-quadword write it computes a single-error-correct, double-error-detect code: a Hamming syndrome over 71 positions plus an overall parity bit. On every read it recomputes the syndrome, classifies the word as clean, correctable or uncorrectable, and returns the data. A 2-bit integrity mode selects the behaviour:

- `00`: checking is off.
- `01`: errors are flagged but the data is left as it was read.
- `10`: single-bit errors are corrected on the way out.
- `11`: as `10`, and a corrected word is also written back to memory in hardware.

A write that enables fewer than all eight bytes is done as a read, a merge and a write when checking is active, so the check byte always covers the whole quadword. Each of eight address rows carries its own enable bit. A row whose bit is clear is treated as unprotected. Error events go out as one-cycle pulses, together with the quadword address and the row, to a separate logging block.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: A write with byte enable 8'hFF is issued to memory in its acceptance cycle with all nine lanes enabled (mask 9'h1FF). Lane 8 (bits 71:64) holds the code of the data: bits 6:0 are the Hamming bits, where bit k is the XOR of the data bits whose position has bit k set, data bit i taking the i-th position in 3..71 that is not a power of two. Bit 7 makes the parity of all 72 bits even. No read phase occurs, so host_ready stays high.
- R2: In mode 2'b00, reads return the stored low 64 bits unchanged and never pulse an error. A partial write is issued at once, enabling only lanes 0..7 whose host_be bit is set and leaving lane 8 untouched.
- R3: In mode 2'b01, a single-bit error pulses err_sbe and a double-bit error pulses err_mbe, and rsp_data is the raw stored data.
- R4: In modes 2'b10 and 2'b11, a flip of any one of the 72 stored bits is corrected in rsp_data and pulses err_sbe without err_mbe.
- R5: With checking active, a two-bit error pulses err_mbe without err_sbe and returns the raw data, and no memory write follows it.
- R6: The row of an address is its top three bits. When the row's bit in row_ecc_en is 0, that row behaves as in R2 under every mode, and its reads never pulse an error.
- R7: With checking active, a partial write takes two cycles with host_ready low in the second. The memory is read, then written with all nine lanes. The written data takes byte i from host_wdata where host_be[i]=1 and from the read word otherwise; in modes 10/11 the read word is first corrected. The check byte is computed fresh.
- R8: A partial write whose read phase finds an error that is not corrected is discarded and leaves memory unchanged. Such an error is a double-bit error, or any error in mode 01. The error is still pulsed.
- R9: In mode 2'b11, a read that finds a single-bit error writes the corrected word and fresh code back to the same address in the next cycle, with host_ready low for that cycle. In mode 2'b10 no write-back happens.
- R10: err_sbe and err_mbe last exactly one cycle, during which err_addr holds the quadword address and err_row its row.
- R11: A read's rsp_valid, rsp_data and error pulses appear in the cycle after acceptance. While reset is held and after it, host_ready is high, and rsp_valid, err_sbe, err_mbe and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct and scrub |
| row_ecc_en | input | ROWS | Per-row protection enable |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Controller can accept a request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Quadword address |
| host_be | input | 8 | Byte enables for a write |
| host_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data, corrected when the mode allows |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wmask | output | 9 | Lane write mask, lane 8 = check byte |
| mem_wdata | output | 72 | Memory write word {check, data} |
| mem_rdata | input | 72 | Memory read word, one cycle after a read strobe |
| err_sbe | output | 1 | Correctable error pulse |
| err_mbe | output | 1 | Uncorrectable error pulse |
| err_addr | output | ADDR_W | Address of the flagged word |
| err_row | output | $clog2(ROWS) | Row of the flagged word |

## Verification
The timing of each result is fixed. A full or unprotected write reaches the memory at its acceptance edge. A read's data and error pulses are valid in the following cycle. A read-modify-write puts its flags and its memory write in that same following cycle. A scrub write occupies the cycle after the read response. The bench drives and samples on the falling edge. It reads the response one falling edge after the accepting rising edge, and host_ready and the absence of a repeated pulse one falling edge later. It inspects its own memory model only after the controller is back at idle. The sweeps flip each of the 72 stored bits and pairs of bits under each mode. Expected data, flags and check bytes are computed by a separate code builder in the bench.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;
  localparam int DW     = 64;       // quadword width
  localparam int PW     = 7;        // Hamming syndrome width
  localparam int CW     = PW + 1;   // check byte: Hamming bits plus overall parity
  localparam int NB     = DW / 8;   // byte lanes
  localparam int MAXPOS = DW + PW;  // highest Hamming position in use

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_DETECT  = 2'b01,
    MODE_CORRECT = 2'b10,
    MODE_SCRUB   = 2'b11
  } ecc_mode_e;

  // Hamming position of data bit idx: the idx-th non-power-of-two in 3..MAXPOS.
  function automatic logic [PW-1:0] data_pos(input int idx);
    int cnt;
    logic [PW-1:0] res;
    cnt = 0;
    res = '0;
    for (int p = 3; p <= MAXPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = PW'(p);
        cnt++;
      end
    end
    return res;
  endfunction

  // XOR of the positions of all set data bits.
  function automatic logic [PW-1:0] hamming_bits(input logic [DW-1:0] d);
    logic [PW-1:0] h;
    h = '0;
    for (int i = 0; i < DW; i++) begin
      if (d[i]) h = h ^ data_pos(i);
    end
    return h;
  endfunction

  // Check byte: {overall parity, Hamming bits}, total word parity even.
  function automatic logic [CW-1:0] ecc_gen(input logic [DW-1:0] d);
    logic [PW-1:0] h;
    h = hamming_bits(d);
    return {^{d, h}, h};
  endfunction
endpackage

// File: rtl/ecc_mem_decode.sv
module ecc_mem_decode
  import ecc_mem_pkg::*;
(
  input  logic [DW-1:0] raw,
  input  logic [CW-1:0] chk,
  input  logic          check_en,
  input  logic          fix_en,
  output logic [DW-1:0] dout,
  output logic          sbe,
  output logic          mbe
);
  logic [PW-1:0] syn;
  logic          odd;
  logic          bad_pos;
  logic [DW-1:0] flip;

  always_comb begin
    syn     = hamming_bits(raw) ^ chk[PW-1:0];
    odd     = ^{raw, chk};
    bad_pos = (syn > PW'(MAXPOS));
    for (int i = 0; i < DW; i++) flip[i] = (data_pos(i) == syn);
    sbe  = check_en && odd && !bad_pos;
    mbe  = check_en && (((syn != '0) && !odd) || (odd && bad_pos));
    dout = (fix_en && sbe) ? (raw ^ flip) : raw;
  end
endmodule

// File: rtl/ecc_mem_merge.sv
module ecc_mem_merge
  import ecc_mem_pkg::*;
(
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] upd,
  input  logic [NB-1:0] be,
  output logic [DW-1:0] merged
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[b*8 +: 8] = be[b] ? upd[b*8 +: 8] : base[b*8 +: 8];
  end
endmodule

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
  import ecc_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ROWS   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic [ROWS-1:0]          row_ecc_en,
  input  logic                     host_valid,
  output logic                     host_ready,
  input  logic                     host_we,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [NB-1:0]            host_be,
  input  logic [DW-1:0]            host_wdata,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_data,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [NB:0]              mem_wmask,
  output logic [DW+CW-1:0]         mem_wdata,
  input  logic [DW+CW-1:0]         mem_rdata,
  output logic                     err_sbe,
  output logic                     err_mbe,
  output logic [ADDR_W-1:0]        err_addr,
  output logic [$clog2(ROWS)-1:0]  err_row
);
  localparam int ROW_W = $clog2(ROWS);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_RMW, ST_SCRUB} state_e;

  state_e              state;
  logic [ADDR_W-1:0]   addr_q;
  logic [NB-1:0]       be_q;
  logic [DW-1:0]       wdata_q;
  logic [DW-1:0]       fix_q;

  // named internal events
  logic                host_full;
  logic                host_prot;
  logic                host_direct;
  logic [ROW_W-1:0]    q_row;
  logic                q_prot;
  logic                dec_en;
  logic [DW-1:0]       dec_dout;
  logic                dec_sbe;
  logic                dec_mbe;
  logic [DW-1:0]       merged;
  logic                rmw_drop;
  logic                scrub_go;

  assign host_full   = &host_be;
  assign host_prot   = (mode != MODE_OFF) && row_ecc_en[host_addr[ADDR_W-1 -: ROW_W]];
  assign host_direct = host_full || !host_prot;
  assign q_row       = addr_q[ADDR_W-1 -: ROW_W];
  assign q_prot      = (mode != MODE_OFF) && row_ecc_en[q_row];
  assign dec_en      = q_prot && ((state == ST_READ) || (state == ST_RMW));

  ecc_mem_decode u_dec (
    .raw      (mem_rdata[DW-1:0]),
    .chk      (mem_rdata[DW +: CW]),
    .check_en (dec_en),
    .fix_en   (mode[1]),
    .dout     (dec_dout),
    .sbe      (dec_sbe),
    .mbe      (dec_mbe)
  );

  ecc_mem_merge u_merge (
    .base   (dec_dout),
    .upd    (wdata_q),
    .be     (be_q),
    .merged (merged)
  );

  assign rmw_drop = dec_mbe || (dec_sbe && !mode[1]);
  assign scrub_go = (state == ST_READ) && dec_sbe && (mode == MODE_SCRUB);

  assign host_ready = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_READ);
  assign rsp_data   = dec_dout;
  assign err_sbe    = dec_sbe;
  assign err_mbe    = dec_mbe;
  assign err_addr   = addr_q;
  assign err_row    = q_row;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = host_addr;
    mem_wmask = '0;
    mem_wdata = {ecc_gen(host_wdata), host_wdata};
    case (state)
      ST_IDLE: begin
        if (host_valid) begin
          mem_req = 1'b1;
          if (host_we && host_direct) begin
            mem_we    = 1'b1;
            mem_wmask = {host_full, host_be};
          end
        end
      end
      ST_RMW: begin
        if (!rmw_drop) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = addr_q;
          mem_wmask = '1;
          mem_wdata = {ecc_gen(merged), merged};
        end
      end
      ST_SCRUB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = addr_q;
        mem_wmask = '1;
        mem_wdata = {ecc_gen(fix_q), fix_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      fix_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (host_valid) begin
            addr_q  <= host_addr;
            be_q    <= host_be;
            wdata_q <= host_wdata;
            if (!host_we)          state <= ST_READ;
            else if (!host_direct) state <= ST_RMW;
          end
        end
        ST_READ: begin
          fix_q <= dec_dout;
          state <= scrub_go ? ST_SCRUB : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a full write goes straight to memory with every lane enabled
  assert_full_write_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && host_we && host_full)
      |-> (mem_req && mem_we && (mem_wmask == '1) && (mem_addr == host_addr)));

  // R1: whenever the check lane is written it carries the code of the data lanes
  assert_check_lane_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wmask[NB])
      |-> (mem_wdata[DW +: CW] == ecc_gen(mem_wdata[DW-1:0])));

  // R4: the response differs from the stored data in at most one bit
  assert_fix_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_data ^ mem_rdata[DW-1:0]) <= 1));

  // R5: an uncorrectable word is never written in the cycle it is seen
  assert_mbe_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_mbe |-> !(mem_req && mem_we));

  // R5: and no scrub follows it
  assert_mbe_no_scrub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_mbe |=> host_ready);

  // R6: an unprotected row or mode never reports
  assert_quiet_unprotected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sbe || err_mbe) |-> ((mode != MODE_OFF) && row_ecc_en[err_row]));

  // R9: a scrub write only follows a correctable error in scrub mode, at its address
  assert_scrub_after_sbe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCRUB)
      |-> ($past(err_sbe) && (mode == MODE_SCRUB) && mem_req && mem_we
           && (mem_addr == $past(err_addr))));

  // R10: error pulses last a single cycle
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sbe || err_mbe) |=> !(err_sbe || err_mbe));
endmodule

// File: tb/ecc_mem_ctrl_test.sv
`timescale 1ns/1ps
module ecc_mem_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [7:0]  row_ecc_en;
  logic        host_valid, host_ready, host_we;
  logic [7:0]  host_addr;
  logic [7:0]  host_be;
  logic [63:0] host_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [8:0]  mem_wmask;
  logic [71:0] mem_wdata;
  logic [71:0] mem_rdata;
  logic        err_sbe, err_mbe;
  logic [7:0]  err_addr;
  logic [2:0]  err_row;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [71:0] mem [0:255];

  always #2 clk = ~clk;

  ecc_mem_ctrl #(.ADDR_W(8), .ROWS(8)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .row_ecc_en(row_ecc_en),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wmask(mem_wmask), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_sbe(err_sbe), .err_mbe(err_mbe), .err_addr(err_addr), .err_row(err_row)
  );

  // synchronous memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 9; b++)
          if (mem_wmask[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  // independent code builder: lay data into a 72-slot codeword, then sum parities
  function automatic logic [7:0] ref_code(input logic [63:0] d);
    logic [71:0] cw;
    logic [6:0]  c;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p < 72; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        cw[p] = d[k];
        k++;
      end
    end
    c = '0;
    for (int p = 1; p < 72; p++)
      for (int b = 0; b < 7; b++)
        if (((p >> b) & 1) == 1) c[b] = c[b] ^ cw[p];
    return {(^d) ^ (^c), c};
  endfunction

  function automatic logic [63:0] ref_merge(input logic [63:0] base, input logic [63:0] upd,
                                            input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = be[b] ? upd[b*8 +: 8] : base[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] pat(input int n);
    return {32'(n * 32'h9E3779B9), 32'(n * 32'h85EBCA6B) ^ 32'h5BD1E995};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (!host_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] be, input logic [63:0] d,
                          output logic rdy_after, output logic sb, output logic mb);
    wait_idle();
    host_valid = 1'b1; host_we = 1'b1; host_addr = a; host_be = be; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
    rdy_after = host_ready; sb = err_sbe; mb = err_mbe;
    wait_idle();
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [63:0] ed, input logic esb,
                           input logic emb, input logic escrub, input string tag);
    logic rv, sb, mb, rn, e2;
    logic [63:0] d;
    logic [7:0] ea;
    logic [2:0] er;
    wait_idle();
    host_valid = 1'b1; host_we = 1'b0; host_addr = a; host_be = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    rv = rsp_valid; d = rsp_data; sb = err_sbe; mb = err_mbe; ea = err_addr; er = err_row;
    @(negedge clk);
    rn = host_ready; e2 = err_sbe | err_mbe;
    wait_idle();
    chk(rv == 1'b1, {tag, " R11 rsp_valid"}, 72'(rv), 72'(1));
    chk(d == ed, {tag, " data"}, 72'(d), 72'(ed));
    chk(sb == esb, {tag, " err_sbe"}, 72'(sb), 72'(esb));
    chk(mb == emb, {tag, " err_mbe"}, 72'(mb), 72'(emb));
    if (esb || emb) begin
      chk(ea == a, {tag, " R10 err_addr"}, 72'(ea), 72'(a));
      chk(er == a[7:5], {tag, " R10 err_row"}, 72'(er), 72'(a[7:5]));
    end
    chk(rn == !escrub, {tag, " R9 ready after response"}, 72'(rn), 72'(!escrub));
    chk(e2 == 1'b0, {tag, " R10 pulse length"}, 72'(e2), 72'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ra, sb, mb;
    logic [63:0] d, m, nd;
    logic [71:0] w, bad;
    logic [7:0] a;

    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem_rdata = '0;
    rst_n = 1'b0; mode = 2'b10; row_ecc_en = 8'hFF;
    host_valid = 1'b0; host_we = 1'b0; host_addr = '0; host_be = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    chk(host_ready == 1'b1, "R11 ready in reset", 72'(host_ready), 72'(1));
    chk({rsp_valid, err_sbe, err_mbe, mem_req} == 4'b0, "R11 quiet in reset",
        72'({rsp_valid, err_sbe, err_mbe, mem_req}), 72'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ready == 1'b1 && rsp_valid == 1'b0, "R11 after reset",
        72'({host_ready, rsp_valid}), 72'(2'b10));

    // R1: full writes and clean read-back
    for (int n = 0; n < 16; n++) begin
      a = 8'(n * 17);
      d = pat(n + 1);
      do_write(a, 8'hFF, d, ra, sb, mb);
      chk(ra == 1'b1, "R1 no read phase", 72'(ra), 72'(1));
      chk(mem[a] == {ref_code(d), d}, "R1 stored word", mem[a], {ref_code(d), d});
      rd_expect(a, d, 1'b0, 1'b0, 1'b0, "R1 clean read");
    end

    // R4: every single-bit flip in correct mode; R9: no write-back in mode 10
    mode = 2'b10;
    a = 8'h05; d = pat(40);
    do_write(a, 8'hFF, d, ra, sb, mb);
    w = mem[a];
    for (int j = 0; j < 72; j++) begin
      bad = w ^ (72'(1) << j);
      mem[a] = bad;
      rd_expect(a, d, 1'b1, 1'b0, 1'b0, "R4 single flip mode10");
      chk(mem[a] == bad, "R9 mode10 leaves memory", mem[a], bad);
    end

    // R9: scrub mode writes the corrected word back
    mode = 2'b11;
    a = 8'hA7; d = pat(41);
    do_write(a, 8'hFF, d, ra, sb, mb);
    w = mem[a];
    for (int j = 0; j < 72; j++) begin
      mem[a] = w ^ (72'(1) << j);
      rd_expect(a, d, 1'b1, 1'b0, 1'b1, "R4 R9 single flip mode11");
      chk(mem[a] == w, "R9 scrubbed word", mem[a], w);
    end
    rd_expect(a, d, 1'b0, 1'b0, 1'b0, "R9 clean after scrub");

    // R5: double flips in modes 10 and 11
    for (int md = 2; md < 4; md++) begin
      mode = 2'(md);
      for (int j = 0; j < 72; j++) begin
        for (int s = 0; s < 2; s++) begin
          bad = w ^ (72'(1) << j) ^ (72'(1) << ((j + (s == 0 ? 1 : 13)) % 72));
          mem[a] = bad;
          rd_expect(a, bad[63:0], 1'b0, 1'b1, 1'b0, "R5 double flip");
          chk(mem[a] == bad, "R5 no write after mbe", mem[a], bad);
        end
      end
    end
    mem[a] = w;

    // R3: detect-only mode returns raw data with flags
    mode = 2'b01;
    for (int j = 0; j < 64; j++) begin
      bad = w ^ (72'(1) << j);
      mem[a] = bad;
      rd_expect(a, bad[63:0], 1'b1, 1'b0, 1'b0, "R3 detect single");
      bad = bad ^ (72'(1) << ((j + 29) % 72));
      mem[a] = bad;
      rd_expect(a, bad[63:0], 1'b0, 1'b1, 1'b0, "R3 detect double");
    end
    mem[a] = w;

    // R7: partial writes with ECC active, including a corrected base
    mode = 2'b10;
    a = 8'h33;
    for (int n = 0; n < 8; n++) begin
      d = pat(60 + n);
      do_write(a, 8'hFF, d, ra, sb, mb);
      nd = pat(80 + n);
      if (n == 3) mem[a] = mem[a] ^ (72'(1) << 20);
      do_write(a, 8'((n * 8'h5B) ^ 8'h81), nd, ra, sb, mb);
      m = ref_merge(d, nd, 8'((n * 8'h5B) ^ 8'h81));
      chk(ra == 1'b0, "R7 ready low in merge cycle", 72'(ra), 72'(0));
      chk(sb == (n == 3), "R7 flag during read phase", 72'(sb), 72'(n == 3));
      chk(mem[a] == {ref_code(m), m}, "R7 merged word", mem[a], {ref_code(m), m});
      rd_expect(a, m, 1'b0, 1'b0, 1'b0, "R7 merged read");
    end

    // R8: partial writes discarded on uncorrected errors
    w = mem[a];
    bad = w ^ (72'(1) << 3) ^ (72'(1) << 50);
    mem[a] = bad;
    do_write(a, 8'h0F, pat(90), ra, sb, mb);
    chk(mb == 1'b1, "R8 mbe flagged", 72'(mb), 72'(1));
    chk(mem[a] == bad, "R8 mbe write discarded", mem[a], bad);
    mode = 2'b01;
    bad = w ^ (72'(1) << 9);
    mem[a] = bad;
    do_write(a, 8'hF0, pat(91), ra, sb, mb);
    chk(sb == 1'b1, "R8 detect sbe flagged", 72'(sb), 72'(1));
    chk(mem[a] == bad, "R8 detect write discarded", mem[a], bad);
    mem[a] = w;
    do_write(a, 8'h3C, pat(92), ra, sb, mb);
    m = ref_merge(w[63:0], pat(92), 8'h3C);
    chk(mem[a] == {ref_code(m), m}, "R7 detect mode clean merge", mem[a], {ref_code(m), m});

    // R2: mode off
    mode = 2'b10;
    a = 8'h21; d = pat(100);
    do_write(a, 8'hFF, d, ra, sb, mb);
    w = mem[a];
    mode = 2'b00;
    nd = pat(101);
    do_write(a, 8'h0F, nd, ra, sb, mb);
    chk(ra == 1'b1, "R2 partial without read phase", 72'(ra), 72'(1));
    chk(mem[a] == {w[71:32], nd[31:0]}, "R2 lanes only", mem[a], {w[71:32], nd[31:0]});
    rd_expect(a, {w[63:32], nd[31:0]}, 1'b0, 1'b0, 1'b0, "R2 mismatched code ignored");
    for (int j = 0; j < 72; j += 7) begin
      bad = w ^ (72'(1) << j);
      mem[a] = bad;
      rd_expect(a, bad[63:0], 1'b0, 1'b0, 1'b0, "R2 flip ignored");
    end

    // R6: per-row enable
    mode = 2'b11;
    row_ecc_en = 8'hF7;
    a = 8'h62; d = pat(110);
    do_write(a, 8'hFF, d, ra, sb, mb);
    w = mem[a];
    chk(w == {ref_code(d), d}, "R6 R1 full write in unprotected row", w, {ref_code(d), d});
    bad = w ^ (72'(1) << 7);
    mem[a] = bad;
    rd_expect(a, bad[63:0], 1'b0, 1'b0, 1'b0, "R6 unprotected row");
    chk(mem[a] == bad, "R6 no scrub in unprotected row", mem[a], bad);
    bad = w ^ (72'(1) << 7) ^ (72'(1) << 8);
    mem[a] = bad;
    rd_expect(a, bad[63:0], 1'b0, 1'b0, 1'b0, "R6 unprotected double");
    mem[a] = w;
    nd = pat(111);
    do_write(a, 8'hC0, nd, ra, sb, mb);
    m = ref_merge(d, nd, 8'hC0);
    chk(ra == 1'b1, "R6 partial direct", 72'(ra), 72'(1));
    chk(mem[a] == {w[71:64], m}, "R6 check lane untouched", mem[a], {w[71:64], m});
    a = 8'h82; d = pat(112);
    do_write(a, 8'hFF, d, ra, sb, mb);
    w = mem[a];
    mem[a] = w ^ (72'(1) << 7);
    rd_expect(a, d, 1'b1, 1'b0, 1'b1, "R6 protected neighbour row");
    chk(mem[a] == w, "R6 neighbour scrubbed", mem[a], w);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule